// File: doc/BRIEF.md
# SCSI Host Status and Handshake Port

This block is the host side of a small SCSI attachment that sits behind a disk controller's register window. It brings the target's bus phase lines (REQ, C/D, I/O, BSY, MSG) into the host clock domain through a synchronizer chain. It shows them, with a data-request flag, in a status byte that the host can read.

Two writable registers drive the bus side. One is a control output byte, and one of its bits enables the interrupt. The other is the data byte presented to the target. Writing the data byte or reading the data input completes the REQ/ACK handshake for one byte. ACK rises if REQ is present and drops once REQ goes away.

The interrupt request is raised only in the status or message-in phase, where I/O, C/D and REQ are all asserted, and only while the enable bit is set. When the bus turns to the target-to-initiator direction, the data output byte is cleared so the host stops driving stale data.

Top module: `scsi_host_port`

## Requirements
- R1: A read at offset 0x00 returns the status byte: bit 7 REQ, bit 6 C/D, bit 5 I/O, bit 4 BSY, bit 3 MSG, all active-high after synchronization, bit 0 the data-request flag, bits 2 and 1 zero. `rdata_o` is combinational on `addr_i`, and offsets other than 0x00 and 0x08 read zero.
- R2: A write at offset 0x00 loads `ctrl_o`, and a write at offset 0x08 loads `dout_o`, each on the next clock edge. A write to any other offset changes neither register.
- R3: A write at offset 0x08, or a read at offset 0x08 (`rd_en_i`), raises `ack_o` on the next edge if synchronized REQ is asserted. If REQ is low, `ack_o` stays low.
- R4: Once high, `ack_o` stays high while synchronized REQ stays high. It falls on the edge after synchronized REQ reads low.
- R5: `irq_o` is a register that takes I/O AND C/D AND REQ (synchronized) AND control bit 0 (the interrupt enable) on every edge.
- R6: On the edge after synchronized I/O rises, `dout_o` becomes zero. This clearing takes priority over a data write in the same cycle.
- R7: The data-request flag (`drq_o`, status bit 0) is set on the edge after synchronized REQ rises while synchronized C/D is low. A data write or data read at offset 0x08 clears it, and a set in the same cycle wins over the clear.
- R8: While `rst_n` is low, the following are all zero: the synchronized bus bits, `ctrl_o` (so the interrupt enable), `dout_o`, `ack_o`, `irq_o` and `drq_o`.
- R9: Each bus phase input passes through two flip-flops. A pin change made between edges shows in the status byte after the second following edge.
- R10: A read at offset 0x08 returns `bus_din_i` as it is on the pins, without synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Target REQ, asynchronous |
| bus_cd_i | input | 1 | Target C/D, asynchronous |
| bus_io_i | input | 1 | Target I/O (high = target to initiator), asynchronous |
| bus_bsy_i | input | 1 | Target BSY, asynchronous |
| bus_msg_i | input | 1 | Target MSG, asynchronous |
| bus_din_i | input | 8 | Data byte from the target |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read at offset 0x08 acknowledges a byte) |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ctrl_o | output | 8 | Control output register (bit 0 is interrupt enable) |
| dout_o | output | 8 | Data output register |
| ack_o | output | 1 | ACK to the target |
| irq_o | output | 1 | Interrupt request |
| drq_o | output | 1 | Data-request flag |

## Verification
A wrong internal state shows at the ports within one or two edges. A stuck or late synchronizer stage shifts the status byte and `irq_o` by a cycle against the model. An ACK register that fails to drop keeps `ack_o` high on the edge after REQ falls. A lost edge detector shows up as `drq_o` never rising, or `dout_o` keeping its value after I/O turns. The bench compares every output against a behavioural model on every clock, so each of these appears at the first differing edge.

// File: rtl/scsi_port_pkg.sv
package scsi_port_pkg;

   typedef struct packed {
      logic req;
      logic cd;
      logic io;
      logic bsy;
      logic msg;
   } bus_phase_t;

   localparam int PHASE_W = $bits(bus_phase_t);
   localparam int BYTE_W  = 8;

   function automatic logic [BYTE_W-1:0] pack_status(bus_phase_t ph, logic drq);
      return {ph.req, ph.cd, ph.io, ph.bsy, ph.msg, 2'b00, drq};
   endfunction

endpackage

// File: rtl/scsi_sync.sv
module scsi_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/scsi_handshake.sv
module scsi_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic cd_s,
   input  logic byte_done,
   output logic ack_o,
   output logic drq_o
);
   logic req_d;
   logic req_rise;

   assign req_rise = req_s & ~req_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_d <= 1'b0;
         ack_o <= 1'b0;
         drq_o <= 1'b0;
      end else begin
         req_d <= req_s;
         ack_o <= req_s & (ack_o | byte_done);
         if (req_rise && !cd_s) drq_o <= 1'b1;
         else if (byte_done)    drq_o <= 1'b0;
      end
   end
endmodule

// File: rtl/scsi_out_regs.sv
module scsi_out_regs #(
   parameter int IENA_BIT = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       io_s,
   input  logic       cd_s,
   input  logic       req_s,
   input  logic       ctrl_we,
   input  logic       data_we,
   input  logic [7:0] wdata,
   output logic [7:0] ctrl_o,
   output logic [7:0] dout_o,
   output logic       irq_o
);
   logic io_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_d   <= 1'b0;
         ctrl_o <= '0;
         dout_o <= '0;
         irq_o  <= 1'b0;
      end else begin
         io_d  <= io_s;
         irq_o <= io_s & cd_s & req_s & ctrl_o[IENA_BIT];
         if (ctrl_we) ctrl_o <= wdata;
         if (io_s && !io_d) dout_o <= '0;
         else if (data_we)  dout_o <= wdata;
      end
   end
endmodule

// File: rtl/scsi_host_port.sv
module scsi_host_port
   import scsi_port_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int CTRL_OFS    = 0,
   parameter int DATA_OFS    = 8,
   parameter int IENA_BIT    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req_i,
   input  logic              bus_cd_i,
   input  logic              bus_io_i,
   input  logic              bus_bsy_i,
   input  logic              bus_msg_i,
   input  logic [7:0]        bus_din_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic [7:0]        ctrl_o,
   output logic [7:0]        dout_o,
   output logic              ack_o,
   output logic              irq_o,
   output logic              drq_o
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IENA_BIT < 0 || IENA_BIT >= BYTE_W) begin : g_bad_iena
      $error("IENA_BIT out of range");
   end
   if (CTRL_OFS == DATA_OFS || CTRL_OFS >= (1 << ADDR_W) || DATA_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("register offsets overlap or exceed the address width");
   end

   bus_phase_t bus_raw, bus_s;
   logic       req_s, cd_s, io_s;
   logic       at_ctrl, at_data, ctrl_we, data_we, byte_done;

   assign bus_raw = '{req: bus_req_i, cd: bus_cd_i, io: bus_io_i, bsy: bus_bsy_i, msg: bus_msg_i};

   scsi_sync #(.WIDTH(PHASE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (bus_raw),
      .q_o  (bus_s)
   );

   assign req_s = bus_s.req;
   assign cd_s  = bus_s.cd;
   assign io_s  = bus_s.io;

   assign at_ctrl   = (addr_i == CTRL_A);
   assign at_data   = (addr_i == DATA_A);
   assign ctrl_we   = wr_en_i & at_ctrl;
   assign data_we   = wr_en_i & at_data;
   assign byte_done = at_data & (wr_en_i | rd_en_i);

   scsi_handshake u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_s),
      .cd_s     (cd_s),
      .byte_done(byte_done),
      .ack_o    (ack_o),
      .drq_o    (drq_o)
   );

   scsi_out_regs #(.IENA_BIT(IENA_BIT)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .io_s   (io_s),
      .cd_s   (cd_s),
      .req_s  (req_s),
      .ctrl_we(ctrl_we),
      .data_we(data_we),
      .wdata  (wdata_i),
      .ctrl_o (ctrl_o),
      .dout_o (dout_o),
      .irq_o  (irq_o)
   );

   always_comb begin
      if (at_ctrl)      rdata_o = pack_status(bus_s, drq_o);
      else if (at_data) rdata_o = bus_din_i;
      else              rdata_o = '0;
   end
endmodule

// File: rtl/scsi_host_port_chk.sv
module scsi_host_port_chk #(
   parameter int ADDR_W   = 5,
   parameter int DATA_OFS = 8,
   parameter int IENA_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              req_s,
   input logic              cd_s,
   input logic              io_s,
   input logic [7:0]        ctrl_o,
   input logic [7:0]        dout_o,
   input logic              ack_o,
   input logic              irq_o,
   input logic              drq_o
);
   logic done_req;
   assign done_req = (addr_i == ADDR_W'(DATA_OFS)) && (wr_en_i || rd_en_i);

   assert_ack_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(done_req && req_s));

   assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !req_s) |=> !ack_o);

   assert_irq_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(io_s && cd_s && req_s && ctrl_o[IENA_BIT]));

   assert_dout_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_s) |=> (dout_o == 8'h00));

   assert_drq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drq_o) |-> $past(req_s && !cd_s));
endmodule

bind scsi_host_port scsi_host_port_chk #(
   .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .IENA_BIT(IENA_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
   .req_s(req_s), .cd_s(cd_s), .io_s(io_s), .ctrl_o(ctrl_o), .dout_o(dout_o),
   .ack_o(ack_o), .irq_o(irq_o), .drq_o(drq_o)
);

// File: tb/tb_scsi_host_port.sv
`timescale 1ns/1ps
module tb_scsi_host_port;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       req = 0, cd = 0, io = 0, bsy = 0, msg = 0;
   logic [7:0] din = 0;
   logic       wr_en = 0, rd_en = 0;
   logic [4:0] addr = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata, ctrl, dout;
   logic       ack, irq, drq;

   always #2.5 clk = ~clk;

   scsi_host_port dut (
      .clk(clk), .rst_n(rst_n), .bus_req_i(req), .bus_cd_i(cd), .bus_io_i(io),
      .bus_bsy_i(bsy), .bus_msg_i(msg), .bus_din_i(din), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ctrl_o(ctrl), .dout_o(dout),
      .ack_o(ack), .irq_o(irq), .drq_o(drq)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // behavioural reference model: stage lists [0]=first flop, [1]=second
   int m_s1[5], m_s2[5];           // index 0 req,1 cd,2 io,3 bsy,4 msg
   int m_req_prev, m_io_prev;
   int m_ctrl, m_dout, m_ack, m_irq, m_drq;

   always @(posedge clk) begin
      int done, set_rq;
      cycles++;
      if (!rst_n) begin
         foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; end
         m_req_prev = 0; m_io_prev = 0;
         m_ctrl = 0; m_dout = 0; m_ack = 0; m_irq = 0; m_drq = 0;
      end else begin
         done   = (addr == 8) && (wr_en || rd_en);
         set_rq = m_s2[0] && !m_req_prev && !m_s2[1];
         m_irq  = m_s2[2] && m_s2[1] && m_s2[0] && m_ctrl[0];
         m_ack  = m_s2[0] && (m_ack || done);
         if (set_rq)    m_drq = 1;
         else if (done) m_drq = 0;
         if (m_s2[2] && !m_io_prev)   m_dout = 0;
         else if (wr_en && addr == 8) m_dout = wdata;
         if (wr_en && addr == 0) m_ctrl = wdata;
         m_req_prev = m_s2[0];
         m_io_prev  = m_s2[2];
         foreach (m_s2[i]) m_s2[i] = m_s1[i];
         m_s1[0] = req; m_s1[1] = cd; m_s1[2] = io; m_s1[3] = bsy; m_s1[4] = msg;
      end
      #1;
      begin
         int exp_rd;
         if (addr == 0)
            exp_rd = (m_s2[0] << 7) | (m_s2[1] << 6) | (m_s2[2] << 5) | (m_s2[3] << 4) | (m_s2[4] << 3) | m_drq;
         else if (addr == 8) exp_rd = din;
         else exp_rd = 0;
         chk(addr == 8 ? "R10 data read" : "R1/R9 status read", rdata, exp_rd);
         chk(!rst_n ? "R8 ctrl reset" : "R2 ctrl", ctrl, m_ctrl);
         chk(!rst_n ? "R8 dout reset" : "R2/R6 dout", dout, m_dout);
         chk(!rst_n ? "R8 ack reset" : "R3/R4 ack", ack, m_ack);
         chk(!rst_n ? "R8 irq reset" : "R5 irq", irq, m_irq);
         chk(!rst_n ? "R8 drq reset" : "R7 drq", drq, m_drq);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0; addr = 0;
   endtask

   task automatic rd(logic [4:0] a);
      @(negedge clk); rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0; addr = 0;
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      // R9: status lines appear after two edges
      @(negedge clk); bsy = 1; msg = 1;
      idle(4);
      // R2: control and data registers, plus an unused offset
      wr(5'd0, 8'hA4);
      wr(5'd8, 8'h5C);
      wr(5'd3, 8'hFF);
      // R3: data write with REQ low gives no ACK
      wr(5'd8, 8'h11);
      // R7: REQ rises in data-out phase
      @(negedge clk); req = 1;
      idle(4);
      // R3/R4: write acknowledges, ACK drops after REQ drops
      wr(5'd8, 8'h22);
      idle(2);
      @(negedge clk); req = 0;
      idle(4);
      // R10/R3: data-in byte read acknowledges
      @(negedge clk); din = 8'h3C; io = 1; req = 1;
      idle(4);
      rd(5'd8);
      idle(1);
      @(negedge clk); req = 0;
      idle(4);
      // R6: I/O turn clears dout, with a colliding write
      @(negedge clk); io = 0;
      idle(3);
      wr(5'd8, 8'h77);
      @(negedge clk); io = 1;
      idle(1);
      @(negedge clk); wr_en = 1; addr = 8; wdata = 8'h99;
      @(negedge clk); wr_en = 0; addr = 0;
      idle(2);
      // R5: status phase with and without enable
      @(negedge clk); cd = 1; req = 1;
      idle(4);
      wr(5'd0, 8'h01);
      idle(3);
      wr(5'd0, 8'h00);
      idle(3);
      wr(5'd0, 8'h01);
      idle(2);
      @(negedge clk); cd = 0;
      idle(4);
      // R8: reset in the middle of activity
      @(negedge clk); rst_n = 0;
      idle(3);
      @(negedge clk); rst_n = 1; req = 0; io = 0;
      idle(5);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #20000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule